// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a 32-bit virtual address into a physical address after a translation-cache miss. It walks a two-level page table held in memory. A request carries the virtual address and the kind of access wanted: read, write or execute. The block takes a request only when it is idle. It reads the first-level entry from a table whose base comes from a register input, and the first level is always treated as resident. It then reads the second-level entry through the page that the first entry points to. The memory port is a simple word-read port: the block holds the read strobe and address until the memory acknowledges, with the data valid in the acknowledging cycle.

The walk ends in one of four ways:
- a translation, made of the physical address, the physical page number placed above the untouched 12-bit offset, and the rights of the final entry;
- a fault because the first-level entry is invalid;
- a fault because the second-level entry is invalid;
- a fault because the entry's rights do not allow the access.

A one-cycle completion pulse marks the result. Refilling the translation cache and handling the fault are left to the surrounding logic.

Top module: `ptWalker`

## Requirements
- R1: Only one walk is in progress at a time. A request is taken only in a cycle where reqReady is high, and reqReady is high only while the block is idle. Requests offered during a walk are ignored: they cause no memory read and do not change the result.
- R2: The first memory read of a walk uses the address rootBase + 4 × vaddr[31:22].
- R3: The second read uses the address {L1 entry bits [31:12], vaddr[21:12], 2'b00}. Each read holds memRd high with a stable, word-aligned memAddr until the cycle in which memAck is high. memRdata is taken in that same cycle.
- R4: The entry format is bit 0 valid, bit 1 read allowed, bit 2 write allowed, bit 3 execute allowed, and bits [31:12] the physical page number. If the first-level entry has valid = 0, the walk ends with faultCode = 1 and no second read is made.
- R5: If the second-level entry has valid = 0, the walk ends with faultCode = 2.
- R6: reqAccess is encoded as 0 = read, 1 = write, 2 = execute and 3 = reserved. A valid second-level entry without the matching right ends the walk with faultCode = 3. A reserved access always ends with faultCode = 3.
- R7: A successful walk gives:
  - physAddr = {entry bits [31:12], vaddr[11:0]};
  - resRights = entry bits [3:1];
  - faultCode = 0 and fault = 0.

  A faulted walk gives physAddr = 0 and resRights = 0, with fault = 1.
- R8: done is high for exactly one cycle: the cycle after the edge at which the last read of the walk was acknowledged. fault is high only together with done. reqReady is high again in the cycle after done.
- R9: While reset is held, reqReady = 1, done = 0 and memRd = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Translation request offered |
| reqVaddr | input | 32 | Virtual address to translate |
| reqAccess | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| rootBase | input | 32 | Byte address of the first-level table |
| reqReady | output | 1 | Block is idle and takes a request |
| memRd | output | 1 | Memory word read requested |
| memAddr | output | 32 | Byte address of the entry being read |
| memAck | input | 1 | Memory accepts the read; memRdata valid |
| memRdata | input | 32 | Entry word returned by memory |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Walk ended in a fault (with done) |
| faultCode | output | 2 | 0 none, 1 L1 invalid, 2 L2 invalid, 3 rights |
| physAddr | output | 32 | Translated physical address |
| resRights | output | 3 | Rights of the final entry {exec, write, read} |

## Verification
The hardest case to reach from the ports is a foreign request that arrives while a walk is stalled on a slow memory. It must leave both the read sequence and the final result untouched. The bench reaches it by stretching every memory acknowledgement with wait states. During those wait states it holds reqValid high with an inverted address and access kind. It then checks the number and addresses of the reads that follow, and the translation produced. A cycle-by-cycle stage model in the bench also checks reqReady, memRd and done on every clock. This covers the shorter path, where a first-level fault ends the walk after a single read.

// File: rtl/ptwPkg.sv
package ptwPkg;
  localparam int PTE_VALID_BIT = 0;
  localparam int PTE_READ_BIT  = 1;
  localparam int PTE_WRITE_BIT = 2;
  localparam int PTE_EXEC_BIT  = 3;
  localparam int RIGHTS_W      = 3;

  typedef enum logic [1:0] {
    FC_NONE       = 2'd0,
    FC_L1_INVALID = 2'd1,
    FC_L2_INVALID = 2'd2,
    FC_PERM       = 2'd3
  } faultCodeT;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } accessT;

  typedef struct packed {
    logic      captureReq;
    logic      captureL1;
    logic      captureRes;
    logic      useL2Addr;
    faultCodeT resCode;
  } ctrlStrobeT;
endpackage

// File: rtl/ptwDatapath.sv
module ptwDatapath
  import ptwPkg::*;
#(
  parameter int PA_W     = 32,
  parameter int OFFSET_W = 12,
  parameter int ENT_LOG  = 2,
  localparam int IDX_W   = OFFSET_W - ENT_LOG,
  localparam int VA_W    = 2 * IDX_W + OFFSET_W,
  localparam int DATA_W  = 8 << ENT_LOG,
  localparam int PPN_W   = PA_W - OFFSET_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobeT          strobe,
  input  logic [VA_W-1:0]     reqVaddr,
  input  logic [1:0]          reqAccess,
  input  logic [PA_W-1:0]     rootBase,
  input  logic [DATA_W-1:0]   memRdata,
  output logic [PA_W-1:0]     memAddr,
  output logic                pteValid,
  output logic                permOk,
  output logic [PA_W-1:0]     physAddr,
  output logic [RIGHTS_W-1:0] resRights,
  output faultCodeT           faultCode
);
  logic [VA_W-1:0]     vaddrQ;
  accessT              accQ;
  logic [PPN_W-1:0]    l1PpnQ;
  logic [PA_W-1:0]     physAddrQ;
  logic [RIGHTS_W-1:0] rightsQ;
  faultCodeT           codeQ;

  logic [IDX_W-1:0]    idx1;
  logic [IDX_W-1:0]    idx2;
  logic [PA_W-1:0]     l1Addr;
  logic [PA_W-1:0]     l2Addr;
  logic [PPN_W-1:0]    entryPpn;
  logic                unusedPteBits;

  assign idx1     = vaddrQ[VA_W-1 -: IDX_W];
  assign idx2     = vaddrQ[OFFSET_W +: IDX_W];
  assign l1Addr   = rootBase + PA_W'({idx1, {ENT_LOG{1'b0}}});
  assign l2Addr   = {l1PpnQ, idx2, {ENT_LOG{1'b0}}};
  assign memAddr  = strobe.useL2Addr ? l2Addr : l1Addr;
  assign entryPpn = memRdata[DATA_W-1 -: PPN_W];
  assign pteValid = memRdata[PTE_VALID_BIT];
  assign unusedPteBits = ^memRdata[DATA_W-PPN_W-1:RIGHTS_W+1];

  always_comb begin
    case (accQ)
      ACC_READ:  permOk = memRdata[PTE_READ_BIT];
      ACC_WRITE: permOk = memRdata[PTE_WRITE_BIT];
      ACC_EXEC:  permOk = memRdata[PTE_EXEC_BIT];
      default:   permOk = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaddrQ    <= '0;
      accQ      <= ACC_READ;
      l1PpnQ    <= '0;
      physAddrQ <= '0;
      rightsQ   <= '0;
      codeQ     <= FC_NONE;
    end else begin
      if (strobe.captureReq) begin
        vaddrQ <= reqVaddr;
        accQ   <= accessT'(reqAccess);
      end
      if (strobe.captureL1) l1PpnQ <= entryPpn;
      if (strobe.captureRes) begin
        codeQ <= strobe.resCode;
        if (strobe.resCode == FC_NONE) begin
          physAddrQ <= {entryPpn, vaddrQ[OFFSET_W-1:0]};
          rightsQ   <= memRdata[PTE_EXEC_BIT:PTE_READ_BIT];
        end else begin
          physAddrQ <= '0;
          rightsQ   <= '0;
        end
      end
    end
  end

  assign physAddr  = physAddrQ;
  assign resRights = rightsQ;
  assign faultCode = codeQ;
endmodule

// File: rtl/ptwCtrl.sv
module ptwCtrl
  import ptwPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       memAck,
  input  logic       pteValid,
  input  logic       permOk,
  output logic       reqReady,
  output logic       memRd,
  output logic       done,
  output ctrlStrobeT strobe
);
  typedef enum logic [1:0] {ST_IDLE, ST_L1, ST_L2, ST_RESP} stateT;
  stateT state, stateNext;

  always_comb begin
    stateNext = state;
    strobe    = '{captureReq: 1'b0, captureL1: 1'b0, captureRes: 1'b0,
                  useL2Addr: 1'b0, resCode: FC_NONE};
    reqReady  = 1'b0;
    memRd     = 1'b0;
    done      = 1'b0;
    case (state)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          strobe.captureReq = 1'b1;
          stateNext         = ST_L1;
        end
      end
      ST_L1: begin
        memRd = 1'b1;
        if (memAck) begin
          if (!pteValid) begin
            strobe.captureRes = 1'b1;
            strobe.resCode    = FC_L1_INVALID;
            stateNext         = ST_RESP;
          end else begin
            strobe.captureL1 = 1'b1;
            stateNext        = ST_L2;
          end
        end
      end
      ST_L2: begin
        memRd            = 1'b1;
        strobe.useL2Addr = 1'b1;
        if (memAck) begin
          strobe.captureRes = 1'b1;
          if (!pteValid)    strobe.resCode = FC_L2_INVALID;
          else if (!permOk) strobe.resCode = FC_PERM;
          else              strobe.resCode = FC_NONE;
          stateNext = ST_RESP;
        end
      end
      default: begin
        done      = 1'b1;
        stateNext = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end
endmodule

// File: rtl/ptWalker.sv
module ptWalker
  import ptwPkg::*;
#(
  parameter int PA_W     = 32,
  parameter int OFFSET_W = 12,
  parameter int ENT_LOG  = 2,
  localparam int IDX_W   = OFFSET_W - ENT_LOG,
  localparam int VA_W    = 2 * IDX_W + OFFSET_W,
  localparam int DATA_W  = 8 << ENT_LOG
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic [VA_W-1:0]     reqVaddr,
  input  logic [1:0]          reqAccess,
  input  logic [PA_W-1:0]     rootBase,
  output logic                reqReady,
  output logic                memRd,
  output logic [PA_W-1:0]     memAddr,
  input  logic                memAck,
  input  logic [DATA_W-1:0]   memRdata,
  output logic                done,
  output logic                fault,
  output logic [1:0]          faultCode,
  output logic [PA_W-1:0]     physAddr,
  output logic [RIGHTS_W-1:0] resRights
);
  ctrlStrobeT strobe;
  logic       pteValid;
  logic       permOk;
  faultCodeT  codeQ;

  ptwCtrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .memAck   (memAck),
    .pteValid (pteValid),
    .permOk   (permOk),
    .reqReady (reqReady),
    .memRd    (memRd),
    .done     (done),
    .strobe   (strobe)
  );

  ptwDatapath #(.PA_W(PA_W), .OFFSET_W(OFFSET_W), .ENT_LOG(ENT_LOG)) uData (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .reqVaddr  (reqVaddr),
    .reqAccess (reqAccess),
    .rootBase  (rootBase),
    .memRdata  (memRdata),
    .memAddr   (memAddr),
    .pteValid  (pteValid),
    .permOk    (permOk),
    .physAddr  (physAddr),
    .resRights (resRights),
    .faultCode (codeQ)
  );

  assign faultCode = codeQ;
  assign fault     = done && (codeQ != FC_NONE);
endmodule

// File: rtl/ptwWalkerChecker.sv
module ptwWalkerChecker (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic        reqReady,
  input logic        memRd,
  input logic        memAck,
  input logic [31:0] memAddr,
  input logic        done,
  input logic        fault,
  input logic [31:0] physAddr,
  input logic [2:0]  resRights
);
  // R1: a taken request makes the block busy on the next cycle
  a_r1_busy_after_accept: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  // R3: a read waits with a stable address until acknowledged
  a_r3_hold_until_ack: assert property (@(posedge clk) disable iff (!rstN)
    (memRd && !memAck) |=> (memRd && $stable(memAddr)));

  // R3: entry addresses are word aligned
  a_r3_word_aligned: assert property (@(posedge clk) disable iff (!rstN)
    memRd |-> (memAddr[1:0] == 2'b00));

  // R8: done is a single-cycle pulse followed by idle
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && reqReady));

  // R8: no read and no new request while reporting
  a_r8_quiet_on_done: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!memRd && !reqReady));

  // R8: fault only accompanies done
  a_r8_fault_with_done: assert property (@(posedge clk) disable iff (!rstN)
    fault |-> done);

  // R7: faulted walks report a cleared translation
  a_r7_fault_clears: assert property (@(posedge clk) disable iff (!rstN)
    (done && fault) |-> (physAddr == 32'd0 && resRights == 3'd0));
endmodule

bind ptWalker ptwWalkerChecker uChk (
  .clk       (clk),
  .rstN      (rstN),
  .reqValid  (reqValid),
  .reqReady  (reqReady),
  .memRd     (memRd),
  .memAck    (memAck),
  .memAddr   (memAddr),
  .done      (done),
  .fault     (fault),
  .physAddr  (physAddr),
  .resRights (resRights)
);

// File: tb/sim_ptWalker.sv
module sim_ptWalker;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] ROOT = 32'h0001_0000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] reqVaddr = '0;
  logic [1:0]  reqAccess = '0;
  logic [31:0] rootBase = ROOT;
  logic        reqReady, memRd, done, fault;
  logic [31:0] memAddr, physAddr;
  logic        memAck = 1'b0;
  logic [31:0] memRdata = '0;
  logic [1:0]  faultCode;
  logic [2:0]  resRights;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  int ackDelay = 0;
  int waitCnt = 0;
  int stage = 0;
  logic [31:0] readLog[$];
  logic [31:0] memImg [logic [31:0]];

  always #(CLK_PERIOD/2) clk = ~clk;

  ptWalker u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqVaddr(reqVaddr),
    .reqAccess(reqAccess), .rootBase(rootBase), .reqReady(reqReady),
    .memRd(memRd), .memAddr(memAddr), .memAck(memAck), .memRdata(memRdata),
    .done(done), .fault(fault), .faultCode(faultCode), .physAddr(physAddr),
    .resRights(resRights)
  );

  function automatic logic [31:0] rdMem(input logic [31:0] a);
    if (memImg.exists(a)) return memImg[a];
    return 32'd0;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Memory responder: acknowledges after ackDelay wait cycles
  always @(negedge clk) begin
    if (!rstN) begin
      memAck  = 1'b0;
      waitCnt = 0;
    end else if (memRd && !memAck) begin
      if (waitCnt >= ackDelay) begin
        memAck   = 1'b1;
        memRdata = rdMem(memAddr);
        readLog.push_back(memAddr);
        waitCnt  = 0;
      end else begin
        waitCnt++;
      end
    end else begin
      memAck = 1'b0;
    end
  end

  // Stage model: 0 idle, 1 first read, 2 second read, 3 report
  always @(posedge clk) begin
    if (!rstN) stage <= 0;
    else case (stage)
      0: if (reqValid) stage <= 1;
      1: if (memAck) stage <= memRdata[0] ? 2 : 3;
      2: if (memAck) stage <= 3;
      default: stage <= 0;
    endcase
  end

  // Per-cycle comparison against the stage model (R1, R8)
  always @(negedge clk) begin
    if (rstN && !finished) begin
      check(reqReady == (stage == 0), "R1", "reqReady vs model", 32'(reqReady), 32'(stage == 0));
      check(done == (stage == 3), "R8", "done vs model", 32'(done), 32'(stage == 3));
      check(memRd == (stage == 1 || stage == 2), "R3", "memRd vs model",
            32'(memRd), 32'(stage == 1 || stage == 2));
    end
  end

  task automatic runWalk(input logic [31:0] va, input logic [1:0] acc, input int delay,
                         input bit noise, input string tag);
    logic [31:0] a1, a2, e1, e2, expPa;
    logic [1:0]  expCode;
    logic [2:0]  expRights;
    int          expReads;
    int          guard;
    bit          ok;
    a1 = ROOT + {20'd0, va[31:22], 2'b00};
    e1 = rdMem(a1);
    a2 = {e1[31:12], va[21:12], 2'b00};
    e2 = rdMem(a2);
    expReads = 2; expPa = '0; expRights = '0; ok = 1'b0;
    if (!e1[0]) begin
      expCode = 2'd1; expReads = 1;
    end else if (!e2[0]) begin
      expCode = 2'd2;
    end else begin
      case (acc)
        2'd0: ok = e2[1];
        2'd1: ok = e2[2];
        2'd2: ok = e2[3];
        default: ok = 1'b0;
      endcase
      if (!ok) expCode = 2'd3;
      else begin
        expCode = 2'd0; expPa = {e2[31:12], va[11:0]}; expRights = e2[3:1];
      end
    end
    ackDelay = delay;
    readLog.delete();
    @(negedge clk);
    reqValid = 1'b1; reqVaddr = va; reqAccess = acc;
    @(negedge clk);
    reqValid = 1'b0;
    if (noise) begin
      reqValid = 1'b1; reqVaddr = ~va; reqAccess = ~acc;
      @(negedge clk);
      @(negedge clk);
      reqValid = 1'b0;
    end
    guard = 0;
    while (!done && guard < 500) begin
      @(negedge clk);
      guard++;
    end
    if (guard >= 500) begin
      check(1'b0, tag, "watchdog: no done", 32'(done), 32'd1);
      return;
    end
    check(faultCode == expCode, tag, "faultCode", 32'(faultCode), 32'(expCode));
    check(fault == (expCode != 0), "R8", "fault flag", 32'(fault), 32'(expCode != 0));
    check(physAddr == expPa, "R7", "physAddr", physAddr, expPa);
    check(resRights == expRights, "R7", "resRights", 32'(resRights), 32'(expRights));
    check(readLog.size() == expReads, noise ? "R1" : "R4", "read count",
          32'(readLog.size()), 32'(expReads));
    if (readLog.size() >= 1) check(readLog[0] == a1, "R2", "first read addr", readLog[0], a1);
    if (readLog.size() >= 2 && expReads == 2)
      check(readLog[1] == a2, "R3", "second read addr", readLog[1], a2);
    @(negedge clk);
    check(!done && reqReady, "R8", "done pulse ended, ready again",
          32'({done, reqReady}), 32'b01);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    memImg[ROOT + 32'h004]      = 32'h0002_0001; // idx1=1 -> page 0x00020
    memImg[32'h0002_0008]       = 32'hABCD_E007; // R W
    memImg[32'h0002_001C]       = 32'h1234_5009; // X only
    memImg[32'h0002_0024]       = 32'h5555_500F; // R W X
    memImg[ROOT + 32'hFFC]      = 32'h0003_0001; // idx1=1023 -> page 0x00030
    memImg[32'h0003_0FFC]       = 32'hFFFF_F003; // R

    repeat (3) @(negedge clk);
    check(reqReady == 1'b1 && done == 1'b0 && memRd == 1'b0, "R9", "reset outputs",
          32'({reqReady, done, memRd}), 32'b100);
    rstN = 1'b1;

    runWalk(32'h0040_2345, 2'd0, 0, 1'b0, "R7");   // read hit
    runWalk(32'h0040_2345, 2'd1, 2, 1'b0, "R6");   // write allowed
    runWalk(32'h0040_2345, 2'd2, 1, 1'b0, "R6");   // exec denied
    runWalk(32'h00C0_1000, 2'd0, 0, 1'b0, "R4");   // L1 invalid
    runWalk(32'h00C0_1000, 2'd0, 3, 1'b0, "R4");   // L1 invalid, slow memory
    runWalk(32'h0040_5ABC, 2'd0, 1, 1'b0, "R5");   // L2 invalid
    runWalk(32'h0040_7010, 2'd2, 0, 1'b0, "R6");   // exec only page
    runWalk(32'h0040_7010, 2'd0, 0, 1'b0, "R6");   // read on exec-only
    runWalk(32'h0040_9FFF, 2'd3, 0, 1'b0, "R6");   // reserved access
    runWalk(32'h0040_9FFF, 2'd1, 4, 1'b0, "R6");   // write on full rights
    runWalk(32'hFFFF_FFFF, 2'd0, 2, 1'b0, "R7");   // top indices
    runWalk(32'h0040_2345, 2'd0, 3, 1'b1, "R1");   // stray request mid-walk
    runWalk(32'h0040_7010, 2'd2, 3, 1'b1, "R1");   // stray request mid-walk

    repeat (2) @(negedge clk);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule